// File: doc/BRIEF.md
# Masked internal port decoder

This block looks at every 16-bit I/O port address issued by the processor and decides where the cycle goes. The target can be one of eight internal peripheral groups, the external expansion bus, or nowhere. Each group has an internal enable bit, supplied as an input vector. The block also holds an 8-bit decoding-mask register that software can read and write.

While the expansion bus is switched off, a group responds whenever its enable bit is set, and no cycle is forwarded. While the expansion bus is switched on, a group's effective enable is its mask bit ANDed with its enable bit. A cycle whose port belongs to a disabled group is forwarded to the expansion bus, and so is a cycle that matches no internal group.

The mask register is written only from the processor path; writes that come from the coprocessor are dropped. A hard reset always fills the mask with ones. A soft reset fills it with ones only when the keep flag is low; otherwise the mask keeps its value. The selects and the forward strobe are purely combinational on the address, the request and the enables. The interface is a plain strobe interface with no back-pressure, because a port cycle cannot be stalled by this block.

Top module: `port_mask_decoder`

## Requirements
- R1: While `hard_rst` is high at a clock edge, the mask becomes 0xFF after that edge, whatever the other inputs are.
- R2: With `hard_rst` low and `soft_rst` high at an edge, the mask becomes 0xFF if `soft_keep` is 0 and stays unchanged if `soft_keep` is 1.
- R3: With both resets low, a `wr_en` edge loads `wr_data` into the mask when `wr_cop` is 0; when `wr_cop` is 1 the mask is left unchanged.
- R4: `rd_data` equals the current mask in the same cycle that `rd_en` is high, and is 0 when `rd_en` is low.
- R5: Group hits on fixed addresses. Group 7 is 0x123B. Group 6 is low byte 0x57 or 0x5B with any high byte, or 0x303B. Group 5 is 0xFADF, 0xFBDF or 0xFFDF. Group 4 is 0x133B, 0x143B or 0x153B. Group 3 is low byte 0xE7 or 0xEB. Group 2 is 0x103B or 0x113B. Group 0 is low byte 0xE3.
- R6: Group 1 hits when the address equals `mf_port_a` or `mf_port_b`.
- R7: With `exp_on` = 0 and `iorq` = 1, `dev_sel[g]` rises for the hit group g exactly when `int_en[g]` is 1, regardless of the mask, and `exp_fwd` stays 0.
- R8: With `exp_on` = 1 and `iorq` = 1, a hit group g is selected exactly when `mask[g]` AND `int_en[g]` is 1; otherwise the cycle raises `exp_fwd`.
- R9: With `exp_on` = 1, an `iorq` cycle that hits no group raises `exp_fwd`. With `iorq` = 0, every output is 0.
- R10: At most one `dev_sel` bit is high, and never together with `exp_fwd`. When several groups hit, the group with the highest index owns the cycle, even if that group is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mask register |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| soft_keep | input | 1 | When 1, soft reset keeps the mask |
| wr_en | input | 1 | Mask register write strobe |
| wr_cop | input | 1 | Write comes from the coprocessor (ignored) |
| wr_data | input | 8 | Mask write data |
| rd_en | input | 1 | Mask register read strobe |
| rd_data | output | 8 | Mask read data, 0 when not reading |
| iorq | input | 1 | I/O cycle request |
| addr | input | 16 | I/O port address |
| mf_port_a | input | 16 | First configurable group-1 port |
| mf_port_b | input | 16 | Second configurable group-1 port |
| int_en | input | 8 | Internal enable per group |
| exp_on | input | 1 | Expansion bus enabled |
| dev_sel | output | 8 | One-hot internal group select |
| exp_fwd | output | 1 | Forward cycle to expansion bus |

## Verification
Random addresses are drawn mostly from the decoded ports, with varied high bytes on the low-byte groups. This separates full-address matching from low-byte matching. Random mask and enable vectors are tried with the expansion bus both on and off, which shows whether the mask is wrongly applied while the bus is off and whether forwarding follows the effective enable. Directed cases cover:
- a group-1 port placed on top of a fixed port, to expose the priority rule;
- a coprocessor write followed by a read, to show that it was dropped;
- soft resets with the keep flag at 0 and at 1.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int GRP_N  = 8;
  localparam int ADDR_W = 16;
  localparam int G_STORE  = 0;
  localparam int G_MF     = 1;
  localparam int G_I2C    = 2;
  localparam int G_SPI    = 3;
  localparam int G_UART   = 4;
  localparam int G_MOUSE  = 5;
  localparam int G_SPRITE = 6;
  localparam int G_LAYER  = 7;
endpackage

// File: rtl/port_match.sv
module port_match
  import pdec_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    mf_a,
  input  logic [AW-1:0]    mf_b,
  output logic [GRP_N-1:0] hit
);
  logic [7:0] lo;
  assign lo = addr[7:0];

  always_comb begin
    hit = '0;
    hit[G_LAYER]  = (addr == 16'h123B);
    hit[G_SPRITE] = (lo == 8'h57) || (lo == 8'h5B) || (addr == 16'h303B);
    hit[G_MOUSE]  = (addr == 16'hFADF) || (addr == 16'hFBDF) || (addr == 16'hFFDF);
    hit[G_UART]   = (addr == 16'h133B) || (addr == 16'h143B) || (addr == 16'h153B);
    hit[G_SPI]    = (lo == 8'hE7) || (lo == 8'hEB);
    hit[G_I2C]    = (addr == 16'h103B) || (addr == 16'h113B);
    hit[G_MF]     = (addr == mf_a) || (addr == mf_b);
    hit[G_STORE]  = (lo == 8'hE3);
  end
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         hard_rst,
  input  logic         soft_rst,
  input  logic         soft_keep,
  input  logic         wr_en,
  input  logic         wr_cop,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] mask
);
  logic init_q = 1'b0;

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      mask   <= '1;
      init_q <= 1'b1;
    end else if (soft_rst) begin
      if (!soft_keep) mask <= '1;
    end else if (wr_en && !wr_cop) begin
      mask <= wr_data;
    end
  end

  assign rd_data = rd_en ? mask : '0;

  assert_hard_ones_R1: assert property (@(posedge clk)
    hard_rst |=> (mask == {W{1'b1}}));
  assert_soft_fill_R2: assert property (@(posedge clk) disable iff (!init_q)
    (!hard_rst && soft_rst && !soft_keep) |=> (mask == {W{1'b1}}));
  assert_soft_keep_R2: assert property (@(posedge clk) disable iff (!init_q)
    (!hard_rst && soft_rst && soft_keep) |=> $stable(mask));
  assert_cop_drop_R3: assert property (@(posedge clk) disable iff (!init_q)
    (!hard_rst && !soft_rst && wr_en && wr_cop) |=> $stable(mask));
  assert_cpu_write_R3: assert property (@(posedge clk) disable iff (!init_q)
    (!hard_rst && !soft_rst && wr_en && !wr_cop) |=> (mask == $past(wr_data)));
endmodule

// File: rtl/sel_arbiter.sv
module sel_arbiter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         iorq,
  input  logic         exp_on,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] int_en,
  input  logic [N-1:0] mask,
  output logic [N-1:0] sel,
  output logic         fwd
);
  logic [N-1:0] win;
  logic [N-1:0] eff;

  assign eff = exp_on ? (mask & int_en) : int_en;

  for (genvar g = 0; g < N; g++) begin : g_win
    if (g == N-1) begin : g_top
      assign win[g] = hit[g];
    end else begin : g_low
      assign win[g] = hit[g] && !(|hit[N-1:g+1]);
    end
  end

  assign sel = iorq ? (win & eff) : '0;
  assign fwd = iorq && exp_on && !(|sel);

  assert_sel_onehot_R10: assert property (@(posedge clk)
    $onehot0(sel));
  assert_fwd_excl_R10: assert property (@(posedge clk)
    fwd |-> (sel == '0));
  assert_off_nofwd_R7: assert property (@(posedge clk)
    !exp_on |-> !fwd);
  assert_idle_R9: assert property (@(posedge clk)
    !iorq |-> (sel == '0 && !fwd));
endmodule

// File: rtl/port_mask_decoder.sv
module port_mask_decoder
  import pdec_pkg::*;
(
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic              soft_keep,
  input  logic              wr_en,
  input  logic              wr_cop,
  input  logic [GRP_N-1:0]  wr_data,
  input  logic              rd_en,
  output logic [GRP_N-1:0]  rd_data,
  input  logic              iorq,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] mf_port_a,
  input  logic [ADDR_W-1:0] mf_port_b,
  input  logic [GRP_N-1:0]  int_en,
  input  logic              exp_on,
  output logic [GRP_N-1:0]  dev_sel,
  output logic              exp_fwd
);
  logic [GRP_N-1:0] mask;
  logic [GRP_N-1:0] hit;

  mask_reg #(.W(GRP_N)) i_mask (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .soft_keep(soft_keep),
    .wr_en(wr_en), .wr_cop(wr_cop), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .mask(mask)
  );

  port_match #(.AW(ADDR_W)) i_match (
    .addr(addr), .mf_a(mf_port_a), .mf_b(mf_port_b), .hit(hit)
  );

  sel_arbiter #(.N(GRP_N)) i_arb (
    .clk(clk), .iorq(iorq), .exp_on(exp_on), .hit(hit), .int_en(int_en),
    .mask(mask), .sel(dev_sel), .fwd(exp_fwd)
  );

  assert_sel_hits_R8: assert property (@(posedge clk)
    (dev_sel != '0) |-> ((dev_sel & hit) == dev_sel));
endmodule

// File: tb/test_port_mask_decoder.sv
module test_port_mask_decoder;
  logic clk = 1'b0;
  logic hard_rst, soft_rst, soft_keep, wr_en, wr_cop, rd_en, iorq, exp_on;
  logic [7:0] wr_data, rd_data, int_en, dev_sel;
  logic [15:0] addr, mf_port_a, mf_port_b;
  logic exp_fwd;
  int errors = 0, checks = 0;
  logic [7:0] m_mask;

  always #4 clk = ~clk;

  port_mask_decoder i_port_mask_decoder (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .soft_keep(soft_keep),
    .wr_en(wr_en), .wr_cop(wr_cop), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .iorq(iorq), .addr(addr), .mf_port_a(mf_port_a),
    .mf_port_b(mf_port_b), .int_en(int_en), .exp_on(exp_on),
    .dev_sel(dev_sel), .exp_fwd(exp_fwd)
  );

  function automatic logic [7:0] f_hits(logic [15:0] a, logic [15:0] pa, logic [15:0] pb);
    logic [7:0] h = '0;
    h[7] = (a == 16'h123B);
    h[6] = (a[7:0] == 8'h57) || (a[7:0] == 8'h5B) || (a == 16'h303B);
    h[5] = (a == 16'hFADF) || (a == 16'hFBDF) || (a == 16'hFFDF);
    h[4] = (a == 16'h133B) || (a == 16'h143B) || (a == 16'h153B);
    h[3] = (a[7:0] == 8'hE7) || (a[7:0] == 8'hEB);
    h[2] = (a == 16'h103B) || (a == 16'h113B);
    h[1] = (a == pa) || (a == pb);
    h[0] = (a[7:0] == 8'hE3);
    return h;
  endfunction

  function automatic logic [8:0] f_expect(logic rq, logic on, logic [15:0] a,
      logic [15:0] pa, logic [15:0] pb, logic [7:0] en, logic [7:0] mk);
    logic [7:0] h = f_hits(a, pa, pb);
    logic [7:0] s = '0;
    logic f;
    logic done = 1'b0;
    logic [7:0] e = on ? (en & mk) : en;
    for (int g = 7; g >= 0; g--) begin
      if (!done && h[g]) begin
        done = 1'b1;
        if (e[g]) s[g] = 1'b1;
      end
    end
    if (!rq) s = '0;
    f = rq && on && (s == '0);
    return {f, s};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_dec(string req);
    logic [8:0] e;
    #1;
    e = f_expect(iorq, exp_on, addr, mf_port_a, mf_port_b, int_en, m_mask);
    chk(req, {7'd0, exp_fwd, dev_sel}, {7'd0, e});
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(string req);
    rd_en = 1'b1; #1;
    chk(req, {8'd0, rd_data}, {8'd0, m_mask});
    rd_en = 1'b0; #1;
    chk("R4 idle", {8'd0, rd_data}, 16'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed = 17;
    logic [15:0] pool [12];
    void'($urandom(seed));
    pool = '{16'h123B, 16'h303B, 16'hFBDF, 16'h143B, 16'h113B, 16'h0057,
             16'h005B, 16'h00E7, 16'h00EB, 16'h00E3, 16'h1F3F, 16'h7FFE};
    hard_rst = 1; soft_rst = 0; soft_keep = 0; wr_en = 0; wr_cop = 0; wr_data = 0;
    rd_en = 0; iorq = 0; exp_on = 0; addr = 0; int_en = 8'hFF;
    mf_port_a = 16'h1F3F; mf_port_b = 16'h7FFE;
    cyc(); hard_rst = 0; m_mask = 8'hFF;
    rd_chk("R1 reset mask");
    chk_dec("R9 idle after reset");
    // R3 CPU write, then coprocessor write dropped
    wr_en = 1; wr_data = 8'h5A; cyc(); m_mask = 8'h5A; wr_en = 0;
    rd_chk("R3 cpu write");
    wr_en = 1; wr_cop = 1; wr_data = 8'h00; cyc(); wr_en = 0; wr_cop = 0;
    rd_chk("R3 cop write ignored");
    // R2 soft reset keep then fill
    soft_rst = 1; soft_keep = 1; cyc(); soft_rst = 0;
    rd_chk("R2 soft keep");
    soft_rst = 1; soft_keep = 0; cyc(); soft_rst = 0; m_mask = 8'hFF;
    rd_chk("R2 soft fill");
    // R1 hard reset overrides write
    wr_en = 1; wr_data = 8'h11; cyc(); wr_en = 0; m_mask = 8'h11;
    hard_rst = 1; soft_keep = 1; wr_en = 1; wr_data = 8'h22; cyc();
    hard_rst = 0; wr_en = 0; m_mask = 8'hFF;
    rd_chk("R1 hard overrides");
    // directed decode cases
    iorq = 1; exp_on = 0; addr = 16'hAB57; chk_dec("R5 sprite low byte");
    addr = 16'h123C; chk_dec("R9 near miss bus off");
    exp_on = 1; chk_dec("R9 miss forwards");
    addr = 16'h1F3F; chk_dec("R6 mf port a");
    mf_port_b = 16'h123B; addr = 16'h123B; int_en = 8'h7F;
    chk_dec("R10 overlap top group disabled");
    mf_port_b = 16'h7FFE; int_en = 8'hFF;
    wr_en = 1; wr_data = 8'h00; cyc(); wr_en = 0; m_mask = 8'h00;
    addr = 16'h00E3; chk_dec("R8 masked forwards");
    exp_on = 0; chk_dec("R7 mask ignored bus off");
    iorq = 0; chk_dec("R9 no request");
    // random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      wr_en = 1; wr_data = 8'($urandom); cyc(); wr_en = 0; m_mask = wr_data;
      a = pool[$urandom % 12];
      if (a[15:8] == 8'h00) a[15:8] = 8'($urandom);
      if ($urandom % 8 == 0) a = 16'($urandom);
      addr = a; int_en = 8'($urandom); exp_on = 1'($urandom);
      iorq = ($urandom % 8) != 0;
      chk_dec(exp_on ? "R8 random" : "R7 random");
      chk("R10 onehot", {15'd0, $countones(dev_sel) <= 1}, 16'd1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule